// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block drives an asynchronous serial line from bytes that software writes. A holding register sits in front of the shift register. While one character is shifted out, the next one can wait in the holding register. When double buffering is on, a character that arrives before the current stop bit ends follows that stop bit at once, so there is no idle time between frames. When double buffering is off, the block acts as a classic single-buffered transmitter: a character can be loaded only while the line is idle, and the interrupt flag means that the frame has finished.

Every bit lasts one baud interval. An interval is the time between two pulses on `baud_tick`, which comes from outside the block. A second frame mode sends only the bare data bits, for synchronous shifting. In that mode the block always works single-buffered, whatever the enable input says.

Write-port handshake: a byte is transferred in every cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high in every cycle outside reset. The port never applies back-pressure. A write that arrives when it cannot be queued is either dropped or replaces the waiting byte, as set out below, and in both cases the overrun flag is raised.

Top module: `uart_dbuf_tx`

## Requirements
- R1: While `rst_n` is low and after it rises, `txd` is 1, `tx_irq` is 0 and `overrun` is 0. `wr_ready` equals `rst_n`.
- R2: An asynchronous frame (`sync_mode`=0) is sent on `txd` as one low start bit, then 8 data bits with the LSB first, then one high stop bit. Each bit starts on a `baud_tick` pulse and lasts until the next pulse. When the line is idle, a written byte begins its start bit on the next tick. An idle line is high.
- R3: Double buffering is in effect when `dbuf_en`=1 and `sync_mode`=0. A byte written after a start bit begins and before its stop bit ends is sent next. Its start bit begins on the tick that ends that stop bit, so exactly one stop bit separates the two frames.
- R4: While double buffering is in effect, `tx_irq` is set on the tick where the holding register passes its byte to the shifter.
- R5: With double buffering off, `tx_irq` is set on the tick that ends the last bit of a frame. A write accepted while a frame is being sent is discarded and sets `overrun`. The line then returns to idle after the current frame.
- R6: With `sync_mode`=1, a frame is the 8 data bits only, LSB first, with no start or stop bit, one bit per tick. Double buffering is forced off in this mode, even when `dbuf_en`=1.
- R7: If a byte is written while the holding register already holds one that has not yet been taken, the waiting byte is replaced and `overrun` is set. The newer byte is the one that is sent.
- R8: `tx_irq` stays at 1 until a cycle with `irq_clr`=1. `overrun` stays at 1 until a cycle with `ovr_clr`=1. In the same cycle, a set takes priority over a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_ready | output | 1 | Write accepted (high whenever out of reset) |
| wr_data | input | DATA_W | Byte to transmit |
| dbuf_en | input | 1 | Enables double buffering (ignored in synchronous mode) |
| sync_mode | input | 1 | 1 = bare data-bit synchronous frame, 0 = start/stop frame |
| irq_clr | input | 1 | Clears `tx_irq` |
| ovr_clr | input | 1 | Clears `overrun` |
| txd | output | 1 | Serial data line |
| tx_irq | output | 1 | Sticky transmit interrupt flag |
| overrun | output | 1 | Sticky lost-or-replaced write flag |

## Verification
The bench builds the block with `DATA_W` = 8 and sends a baud pulse every fourth clock, so each asynchronous frame takes 40 cycles. At that rate, a write can be placed inside a frame in a few cycles. This lets the bench reach the chained-frame boundary, the replacement of a waiting byte, a write discarded in single-buffered mode, and the forced single-buffered behaviour in synchronous mode, all within a few hundred cycles per scenario.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;
  typedef enum logic {
    FRM_ASYNC = 1'b0,
    FRM_SYNC  = 1'b1
  } frame_mode_e;
  localparam int unsigned FRAMING_BITS = 2;
endpackage

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              sync_mode,
  output logic              take,
  output logic              frame_done,
  output logic              busy,
  output logic              txd
);
  localparam int unsigned FRM_W = DATA_W + FRAMING_BITS;
  localparam int unsigned CNT_W = $clog2(FRM_W + 1);

  frame_mode_e       mode_in;
  logic [FRM_W-1:0]  rest_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;
  logic              txd_q;
  logic              at_end;

  assign mode_in    = frame_mode_e'(sync_mode);
  assign at_end     = busy_q && (left_q == '0);
  assign take       = baud_tick && hold_full && (!busy_q || at_end);
  assign frame_done = baud_tick && at_end;
  assign busy       = busy_q;
  assign txd        = txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      rest_q <= '1;
      left_q <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      if (mode_in == FRM_SYNC) begin
        txd_q  <= hold_data[0];
        rest_q <= {2'b11, hold_data} >> 1;
        left_q <= CNT_W'(DATA_W - 1);
      end else begin
        txd_q  <= 1'b0;
        rest_q <= {1'b1, 1'b1, hold_data};
        left_q <= CNT_W'(FRM_W - 1);
      end
    end else if (baud_tick && busy_q) begin
      if (at_end) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end else begin
        txd_q  <= rest_q[0];
        rest_q <= {1'b1, rest_q[FRM_W-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end

  // R2: the line changes only on a baud pulse
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd_q));
  // R2: an idle shifter leaves the line high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !take) |=> txd_q);
  // R3: a transfer always leaves the shifter running
  a_r3_take_starts: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy_q);
endmodule

// File: rtl/tx_hold.sv
module tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  input  logic              single,
  input  logic              busy,
  input  logic              ovr_clr,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              overrun
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              ovr_q;
  logic              blocked;
  logic              store;
  logic              ovr_set;

  assign blocked = single && (busy || take);
  assign store   = wr_fire && !blocked;
  assign ovr_set = wr_fire && (blocked || (full_q && !take));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (store) begin
        full_q <= 1'b1;
        data_q <= wr_data;
      end else if (take) begin
        full_q <= 1'b0;
      end
      if (ovr_set)      ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end

  assign full    = full_q;
  assign data    = data_q;
  assign overrun = ovr_q;

  // R7: replacing a waiting byte flags overrun
  a_r7_replace_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && full_q && !take) |=> overrun);
  // R5: a write during a single-buffered frame flags overrun
  a_r5_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && single && busy) |=> overrun);
  // R8: overrun is sticky
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
endmodule

// File: rtl/tx_irq.sv
module tx_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic eff_dbuf,
  input  logic take,
  input  logic frame_done,
  input  logic irq_clr,
  output logic irq
);
  logic irq_q;
  logic irq_set;

  assign irq_set = eff_dbuf ? take : frame_done;

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  assign irq = irq_q;

  // R4: in double-buffered mode a transfer raises the flag
  a_r4_take_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_dbuf && take) |=> irq);
  // R5: in single-buffered mode the end of a frame raises the flag
  a_r5_end_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_dbuf && frame_done) |=> irq);
  // R8: the flag holds until cleared
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbuf_en,
  input  logic              sync_mode,
  input  logic              irq_clr,
  input  logic              ovr_clr,
  output logic              txd,
  output logic              tx_irq,
  output logic              overrun
);
  logic              eff_dbuf;
  logic              wr_fire;
  logic              take;
  logic              frame_done;
  logic              busy;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  assign eff_dbuf = dbuf_en && (frame_mode_e'(sync_mode) == FRM_ASYNC);
  assign wr_ready = rst_n;
  assign wr_fire  = wr_valid && wr_ready;

  tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_data (wr_data),
    .take    (take),
    .single  (!eff_dbuf),
    .busy    (busy),
    .ovr_clr (ovr_clr),
    .full    (hold_full),
    .data    (hold_data),
    .overrun (overrun)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .sync_mode  (sync_mode),
    .take       (take),
    .frame_done (frame_done),
    .busy       (busy),
    .txd        (txd)
  );

  tx_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .eff_dbuf   (eff_dbuf),
    .take       (take),
    .frame_done (frame_done),
    .irq_clr    (irq_clr),
    .irq        (tx_irq)
  );

  // R6: synchronous mode never chains frames, so no transfer happens mid-frame
  a_r6_sync_no_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && busy && !frame_done) |-> !take);
endmodule

// File: tb/uart_dbuf_tx_bench.sv
`timescale 1ns/1ps
module uart_dbuf_tx_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          baud_tick = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          dbuf_en = 1'b0;
  logic          sync_mode = 1'b0;
  logic          irq_clr = 1'b0;
  logic          ovr_clr = 1'b0;
  logic          txd;
  logic          tx_irq;
  logic          overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 2);
  end

  uart_dbuf_tx #(.DATA_W(DW)) u_uart_dbuf_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .dbuf_en(dbuf_en),
    .sync_mode(sync_mode), .irq_clr(irq_clr), .ovr_clr(ovr_clr),
    .txd(txd), .tx_irq(tx_irq), .overrun(overrun)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next_bit(output logic b);
    @(posedge clk iff baud_tick);
    #1 b = txd;
  endtask

  task automatic write_byte(input logic [DW-1:0] v);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = v;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_clr(input bit irq, input bit ovr);
    @(negedge clk);
    irq_clr = irq;
    ovr_clr = ovr;
    @(negedge clk);
    irq_clr = 1'b0;
    ovr_clr = 1'b0;
  endtask

  task automatic wait_start(output bit found);
    logic b;
    found = 1'b0;
    for (int i = 0; i < 20; i++) begin
      next_bit(b);
      if (b == 1'b0) begin
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic data_and_stop(output logic [DW-1:0] v, output logic stop);
    logic b;
    for (int i = 0; i < DW; i++) begin
      next_bit(b);
      v[i] = b;
    end
    next_bit(stop);
  endtask

  task automatic idle_ticks(input int n, input string req);
    logic b;
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      next_bit(b);
      if (b !== 1'b1) lows++;
    end
    check(req, lows, 0);
  endtask

  task automatic t_reset;
    check("R1 txd in reset", txd, 1);
    check("R1 ready in reset", wr_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd after reset", txd, 1);
    check("R1 irq after reset", tx_irq, 0);
    check("R1 overrun after reset", overrun, 0);
    check("R1 ready after reset", wr_ready, 1);
  endtask

  task automatic t_single_frame;
    bit f; logic [DW-1:0] v; logic s;
    dbuf_en = 1'b0;
    write_byte(8'hA5);
    wait_start(f);
    check("R2 start bit seen", f, 1);
    data_and_stop(v, s);
    check("R2 data LSB first", v, 8'hA5);
    check("R2 stop bit high", s, 1);
    check("R5 irq low during stop", tx_irq, 0);
    next_bit(s);
    check("R5 irq at stop end", tx_irq, 1);
    check("R2 idle high", s, 1);
    idle_ticks(3, "R8 irq sticky window");
    check("R8 irq still set", tx_irq, 1);
    pulse_clr(1, 0);
    check("R8 irq cleared", tx_irq, 0);
  endtask

  task automatic t_single_drop;
    bit f; logic [DW-1:0] v; logic s;
    dbuf_en = 1'b0;
    write_byte(8'h0F);
    wait_start(f);
    write_byte(8'hF0);
    check("R5 overrun on mid-frame write", overrun, 1);
    data_and_stop(v, s);
    check("R5 first frame intact", v, 8'h0F);
    idle_ticks(12, "R5 dropped byte not sent");
    check("R5 irq after frame", tx_irq, 1);
    pulse_clr(1, 1);
    check("R8 overrun cleared", overrun, 0);
  endtask

  task automatic t_chain;
    bit f; logic [DW-1:0] v; logic s; logic b;
    dbuf_en = 1'b1;
    write_byte(8'h3C);
    wait_start(f);
    check("R4 irq on transfer", tx_irq, 1);
    pulse_clr(1, 0);
    write_byte(8'h81);
    data_and_stop(v, s);
    check("R3 first frame", v, 8'h3C);
    check("R4 irq low until next transfer", tx_irq, 0);
    next_bit(b);
    check("R3 start right after one stop", b, 0);
    check("R4 irq on chained transfer", tx_irq, 1);
    data_and_stop(v, s);
    check("R3 second frame", v, 8'h81);
    check("R3 second stop", s, 1);
    check("R3 no overrun", overrun, 0);
    idle_ticks(4, "R3 idle after chain");
    pulse_clr(1, 0);
  endtask

  task automatic t_replace;
    bit f; logic [DW-1:0] v; logic s; logic b;
    dbuf_en = 1'b1;
    write_byte(8'h11);
    wait_start(f);
    write_byte(8'h22);
    check("R7 no overrun on first queue", overrun, 0);
    write_byte(8'h33);
    check("R7 overrun on replace", overrun, 1);
    data_and_stop(v, s);
    check("R7 running frame", v, 8'h11);
    next_bit(b);
    check("R7 chained start", b, 0);
    data_and_stop(v, s);
    check("R7 newer byte sent", v, 8'h33);
    idle_ticks(12, "R7 replaced byte not sent");
    pulse_clr(1, 1);
  endtask

  task automatic t_sync;
    bit f; logic [DW-1:0] v; logic b;
    dbuf_en   = 1'b1;
    sync_mode = 1'b1;
    write_byte(8'h52);
    wait_start(f);
    check("R6 first data bit", f, 1);
    v[0] = 1'b0;
    for (int i = 1; i < DW; i++) begin
      next_bit(b);
      v[i] = b;
    end
    check("R6 bare data bits", v, 8'h52);
    check("R6 irq not on transfer", tx_irq, 0);
    write_byte(8'h99);
    check("R6 forced single drops write", overrun, 1);
    next_bit(b);
    check("R6 no stop bit, line idle", b, 1);
    check("R6 irq at frame end", tx_irq, 1);
    idle_ticks(12, "R6 dropped byte not sent");
    sync_mode = 1'b0;
    pulse_clr(1, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single_frame();
    t_single_drop();
    t_chain();
    t_replace();
    t_sync();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule